// File: doc/BRIEF.md
# Auto-Reload Timer/Counter with Interrupt Control

This block is a 16-bit up-counter that reloads itself. When the count passes its top value, it takes its next value from a 16-bit reload register held as two bytes. It also sets an overflow flag. The count advances in one of two ways. It can step once per machine cycle, which the surrounding logic signals with a strobe at one twelfth of the clock rate. Or it can step on falling transitions of an external count pin. A run bit enables counting. An optional gate bit also makes counting depend on the level of the first external interrupt pin.

The same 8-bit control register holds the request flags for two external interrupt pins. Each pin can be edge-sensitive, where a falling edge latches the flag, or level-sensitive, where the flag tracks the inverted pin. All asynchronous pins pass through a synchroniser. Software reaches the control, count and reload bytes through one write/read port with a registered read path. The interrupt controller clears flags through per-source acknowledge inputs when it vectors.

Top module: `reload_tmr_top`

## Requirements
- R1: After reset, the count, the reload value and the control register are all 00h, the three flag outputs are 0, and reading any address returns 00h.
- R2: When the run bit is 1, the gate bit is 0 and the source bit is 0, the count increases by one at each clock edge where `mc_stb` is 1. When `mc_stb` is 0, the count does not change.
- R3: When the source bit is 1, the count increases by one only at a strobe whose synchronised count-pin sample is 0 and whose previous strobe sample was 1. A low pulse that begins and ends between two strobes is not counted. The synchroniser is two flops deep.
- R4: When the gate bit is 1, the count advances only while the synchronised `irq0_pin` is 1.
- R5: When the run bit is 0, the count holds its value.
- R6: A step from FFFFh loads the count from the reload value, leaves the reload value unchanged, and sets the overflow flag on the same edge.
- R7: `ack_tmr` clears the overflow flag. An overflow in the same cycle wins and leaves the flag set. Writing control bit 5 also sets or clears the flag.
- R8: The control byte layout is bit 7 gate, bit 6 source (1 = count pin), bit 5 overflow, bit 4 run, bit 3 irq0 flag, bit 2 irq0 edge mode, bit 1 irq1 flag, bit 0 irq1 edge mode.
- R9: In edge mode, a 1-to-0 change of the synchronised pin sets that pin's flag one clock after the synchroniser output changes. The pin's acknowledge clears the flag. An edge in the same cycle as the acknowledge wins.
- R10: In level mode, a pin's flag equals the inverse of its synchronised pin, one clock later. Control writes to that flag bit and acknowledges have no effect.
- R11: A write to a count byte replaces only that byte and suppresses any increment in the same cycle.
- R12: The address map is 0 control, 1 count low, 2 count high, 3 reload low, 4 reload high; all other addresses read 00h. `rd_data` shows the addressed register one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_stb | input | 1 | Machine-cycle strobe, one clock in twelve |
| cnt_pin | input | 1 | External count pin, asynchronous |
| irq0_pin | input | 1 | External interrupt 0 pin, active low; also the gate input |
| irq1_pin | input | 1 | External interrupt 1 pin, active low |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| rd_data | output | 8 | Registered read data |
| ack_tmr | input | 1 | Vector acknowledge for the overflow source |
| ack_x0 | input | 1 | Vector acknowledge for interrupt 0 |
| ack_x1 | input | 1 | Vector acknowledge for interrupt 1 |
| ovf_flag | output | 1 | Overflow flag |
| x0_req | output | 1 | Interrupt 0 request flag |
| x1_req | output | 1 | Interrupt 1 request flag |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is the overflow set and the acknowledge clear on the overflow flag. The second pair is a new edge and its acknowledge on an interrupt flag. The bench drives `ack_tmr` on the same clock as the strobe that steps the count from FFFFh. It also times `ack_x0` to the exact cycle in which the synchronised falling edge appears. In both cases it expects the flag to stay set. A count-byte write on a strobe cycle is also provoked, and the bench expects only the written byte to change, with no increment.

// File: rtl/reload_tmr_pkg.sv
package reload_tmr_pkg;

  // Control byte; member order fixes bit position, MSB first.
  typedef struct packed {
    logic gate;
    logic src_pin;
    logic ovf;
    logic run;
    logic x0_flag;
    logic x0_edge;
    logic x1_flag;
    logic x1_edge;
  } ctrl_t;

  localparam int CTRL_ADDR = 0;

endpackage

// File: rtl/rt_pin_sync.sv
module rt_pin_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_a,
  output logic [N-1:0] pin_s
);

  // Pins idle high; reset to 1 so no false edge leaves reset.
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '1;
      else     sh <= {sh[STAGES-2:0], pin_a[g]};
    end
    assign pin_s[g] = sh[STAGES-1];
  end

endmodule

// File: rtl/rt_count_core.sv
module rt_count_core #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mc_stb,
  input  logic              cnt_s,
  input  logic              gate_s,
  input  logic              run,
  input  logic              gate,
  input  logic              src_pin,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic              wrap
);

  localparam int NB = CNT_W / DATA_W;

  logic             smp_q;
  logic             tick;
  logic             enable;
  logic             cnt_wr;
  logic             step;
  logic [CNT_W-1:0] count_d;

  // Pin sampled once per machine cycle; count on a 1 then 0 sample pair.
  always_ff @(posedge clk) begin
    if (rst)         smp_q <= 1'b0;
    else if (mc_stb) smp_q <= cnt_s;
  end

  always_comb begin
    tick   = src_pin ? (mc_stb & smp_q & ~cnt_s) : mc_stb;
    enable = run & (~gate | gate_s);
    cnt_wr = wr_en && (wr_addr >= ADDR_W'(1)) && (wr_addr <= ADDR_W'(NB));
    step   = tick & enable & ~cnt_wr;
    wrap   = step & (&count_q);
  end

  always_comb begin
    count_d = count_q;
    if (cnt_wr) begin
      for (int b = 0; b < NB; b++)
        if (wr_addr == ADDR_W'(b + 1)) count_d[b*DATA_W +: DATA_W] = wr_data;
    end else if (step) begin
      count_d = wrap ? reload_q : count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_d;
  end

  logic [DATA_W-1:0] rld_b [NB];
  for (genvar gb = 0; gb < NB; gb++) begin : g_rld
    always_ff @(posedge clk) begin
      if (rst) rld_b[gb] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(NB + 1 + gb)) rld_b[gb] <= wr_data;
    end
    assign reload_q[gb*DATA_W +: DATA_W] = rld_b[gb];
  end

endmodule

// File: rtl/rt_ctrl_reg.sv
module rt_ctrl_reg
  import reload_tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_ctrl,
  input  logic [7:0] wr_data,
  input  logic       wrap,
  input  logic       ack_tmr,
  input  logic       ack_x0,
  input  logic       ack_x1,
  input  logic       x0_s,
  input  logic       x1_s,
  output ctrl_t      ctrl_q
);

  logic  x0_prev, x1_prev;
  ctrl_t nxt;

  function automatic logic flag_next(input logic edge_mode, input logic cand,
                                     input logic ack, input logic fall,
                                     input logic lvl);
    logic f;
    if (!edge_mode) return ~lvl;
    f = cand;
    if (ack)  f = 1'b0;
    if (fall) f = 1'b1;
    return f;
  endfunction

  always_comb begin
    nxt = ctrl_q;
    if (wr_ctrl) nxt = ctrl_t'(wr_data);
    if (ack_tmr) nxt.ovf = 1'b0;
    if (wrap)    nxt.ovf = 1'b1;
    nxt.x0_flag = flag_next(ctrl_q.x0_edge, nxt.x0_flag, ack_x0, x0_prev & ~x0_s, x0_s);
    nxt.x1_flag = flag_next(ctrl_q.x1_edge, nxt.x1_flag, ack_x1, x1_prev & ~x1_s, x1_s);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      x0_prev <= 1'b1;
      x1_prev <= 1'b1;
    end else begin
      ctrl_q  <= nxt;
      x0_prev <= x0_s;
      x1_prev <= x1_s;
    end
  end

endmodule

// File: rtl/reload_tmr_top.sv
module reload_tmr_top
  import reload_tmr_pkg::*;
#(
  parameter  int CNT_W       = 16,
  parameter  int DATA_W      = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int NB          = CNT_W / DATA_W,
  localparam int ADDR_W      = $clog2(2 * NB + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mc_stb,
  input  logic              cnt_pin,
  input  logic              irq0_pin,
  input  logic              irq1_pin,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ack_tmr,
  input  logic              ack_x0,
  input  logic              ack_x1,
  output logic              ovf_flag,
  output logic              x0_req,
  output logic              x1_req
);

  logic [2:0]        pins_s;
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  cnt_val;
  logic [CNT_W-1:0]  rld_val;
  logic              wrap_pulse;
  logic              wr_ctrl;
  logic [DATA_W-1:0] rd_next;

  rt_pin_sync #(.N(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst   (rst),
    .pin_a ({irq1_pin, irq0_pin, cnt_pin}),
    .pin_s (pins_s)
  );

  rt_count_core #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) core_i (
    .clk      (clk),
    .rst      (rst),
    .mc_stb   (mc_stb),
    .cnt_s    (pins_s[0]),
    .gate_s   (pins_s[1]),
    .run      (ctrl_q.run),
    .gate     (ctrl_q.gate),
    .src_pin  (ctrl_q.src_pin),
    .wr_en    (reg_wr),
    .wr_addr  (reg_addr),
    .wr_data  (reg_wdata),
    .count_q  (cnt_val),
    .reload_q (rld_val),
    .wrap     (wrap_pulse)
  );

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR));

  rt_ctrl_reg ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .wr_ctrl (wr_ctrl),
    .wr_data (reg_wdata[7:0]),
    .wrap    (wrap_pulse),
    .ack_tmr (ack_tmr),
    .ack_x0  (ack_x0),
    .ack_x1  (ack_x1),
    .x0_s    (pins_s[1]),
    .x1_s    (pins_s[2]),
    .ctrl_q  (ctrl_q)
  );

  always_comb begin
    rd_next = '0;
    if (reg_addr == ADDR_W'(CTRL_ADDR)) rd_next = DATA_W'(ctrl_q);
    for (int b = 0; b < NB; b++) begin
      if (reg_addr == ADDR_W'(b + 1))      rd_next = cnt_val[b*DATA_W +: DATA_W];
      if (reg_addr == ADDR_W'(NB + 1 + b)) rd_next = rld_val[b*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  assign ovf_flag = ctrl_q.ovf;
  assign x0_req   = ctrl_q.x0_flag;
  assign x1_req   = ctrl_q.x1_flag;

endmodule

// File: rtl/reload_tmr_chk.sv
module reload_tmr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             mc_stb,
  input logic             reg_wr,
  input logic             ack_tmr,
  input logic [7:0]       ctrl_q,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] rld_val,
  input logic             ovf_flag
);

  // R1
  rst_state_chk: assert property (@(posedge clk)
    rst |=> (cnt_val == '0 && rld_val == '0 && ctrl_q == 8'h00));

  // R5
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[4] && !reg_wr) |=> $stable(cnt_val));

  // R2
  strobe_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!mc_stb && !reg_wr) |=> $stable(cnt_val));

  // R6
  reload_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> $stable(rld_val));

  // R6
  wrap_value_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(ovf_flag) && !$past(reg_wr)) |-> cnt_val == $past(rld_val));

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_tmr && !reg_wr && cnt_val != '1) |=> !ovf_flag);

endmodule

bind reload_tmr_top reload_tmr_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .mc_stb   (mc_stb),
  .reg_wr   (reg_wr),
  .ack_tmr  (ack_tmr),
  .ctrl_q   (ctrl_q),
  .cnt_val  (cnt_val),
  .rld_val  (rld_val),
  .ovf_flag (ovf_flag)
);

// File: tb/reload_tmr_top_tb_top.sv
module reload_tmr_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mc_stb = 1'b0, cnt_pin = 1'b1, irq0_pin = 1'b1, irq1_pin = 1'b1;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] rd_data;
  logic       ack_tmr = 1'b0, ack_x0 = 1'b0, ack_x1 = 1'b0;
  logic       ovf_flag, x0_req, x1_req;

  always #4 clk = ~clk;

  reload_tmr_top dut_i (
    .clk(clk), .rst(rst), .mc_stb(mc_stb), .cnt_pin(cnt_pin),
    .irq0_pin(irq0_pin), .irq1_pin(irq1_pin), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_data(rd_data),
    .ack_tmr(ack_tmr), .ack_x0(ack_x0), .ack_x1(ack_x1),
    .ovf_flag(ovf_flag), .x0_req(x0_req), .x1_req(x1_req)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string phase  = "R1";

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: pin history queues, integer registers.
  bit       mdl_ok = 0;
  int       m_cnt, m_rld, m_rd;
  bit [7:0] m_ctl;
  bit       m_smp, m_p0, m_p1;
  bit       qc[$], q0[$], q1[$];

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_rld = 0; m_ctl = 0; m_rd = 0;
      m_smp = 0; m_p0 = 1; m_p1 = 1;
      qc = '{1, 1}; q0 = '{1, 1}; q1 = '{1, 1};
      mdl_ok = 1;
    end else begin
      int a;
      bit sc, s0, s1, tick, en, cw, stp, wrp;
      bit [7:0] nc;
      a  = int'(reg_addr);
      sc = qc[1]; s0 = q0[1]; s1 = q1[1];
      qc.push_front(cnt_pin);  void'(qc.pop_back());
      q0.push_front(irq0_pin); void'(q0.pop_back());
      q1.push_front(irq1_pin); void'(q1.pop_back());
      case (a)
        0: m_rd = m_ctl;
        1: m_rd = m_cnt % 256;
        2: m_rd = m_cnt / 256;
        3: m_rd = m_rld % 256;
        4: m_rd = m_rld / 256;
        default: m_rd = 0;
      endcase
      tick = m_ctl[6] ? (mc_stb && m_smp && !sc) : mc_stb;
      if (mc_stb) m_smp = sc;
      en  = m_ctl[4] && (!m_ctl[7] || s0);
      cw  = reg_wr && (a == 1 || a == 2);
      stp = tick && en && !cw;
      wrp = stp && (m_cnt == 65535);
      nc  = (reg_wr && a == 0) ? reg_wdata : m_ctl;
      if (ack_tmr) nc[5] = 0;
      if (wrp)     nc[5] = 1;
      if (!m_ctl[2]) nc[3] = !s0;
      else begin
        if (ack_x0)        nc[3] = 0;
        if (m_p0 && !s0)   nc[3] = 1;
      end
      if (!m_ctl[0]) nc[1] = !s1;
      else begin
        if (ack_x1)        nc[1] = 0;
        if (m_p1 && !s1)   nc[1] = 1;
      end
      m_p0 = s0; m_p1 = s1;
      if (reg_wr && a == 1)      m_cnt = (m_cnt / 256) * 256 + reg_wdata;
      else if (reg_wr && a == 2) m_cnt = reg_wdata * 256 + m_cnt % 256;
      else if (stp)              m_cnt = wrp ? m_rld : m_cnt + 1;
      if (reg_wr && a == 3) m_rld = (m_rld / 256) * 256 + reg_wdata;
      if (reg_wr && a == 4) m_rld = reg_wdata * 256 + m_rld % 256;
      m_ctl = nc;
    end
  end

  always @(negedge clk) begin
    if (mdl_ok && !done) begin
      cmp({phase, " ovf_flag"}, ovf_flag, m_ctl[5]);
      cmp({phase, " x0_req"},   x0_req,   m_ctl[3]);
      cmp({phase, " x1_req"},   x1_req,   m_ctl[1]);
      cmp({phase, " rd_data"},  rd_data,  m_rd);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    reg_wr = 1; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_chk(string tag, int a, int exp);
    reg_addr = 3'(a);
    @(negedge clk);
    cmp(tag, rd_data, exp);
  endtask

  task automatic strobes(int n);
    repeat (n) begin
      mc_stb = 1; @(negedge clk); mc_stb = 0; cyc(11);
    end
  endtask

  task automatic set_cnt_pin(bit v);
    cnt_pin = v; cyc(4);
  endtask

  initial begin
    cyc(3);
    rst = 0;
    phase = "R1";
    for (int i = 0; i < 5; i++) rd_chk("R1 reset read", i, 0);
    cmp("R1 ovf", ovf_flag, 0);

    phase = "R12";
    wr(1, 8'h34); wr(2, 8'h12); wr(3, 8'hCD); wr(4, 8'hAB);
    rd_chk("R12 cnt lo", 1, 8'h34); rd_chk("R12 cnt hi", 2, 8'h12);
    rd_chk("R12 rld lo", 3, 8'hCD); rd_chk("R12 rld hi", 4, 8'hAB);
    rd_chk("R12 unmapped", 6, 0);

    phase = "R8";
    wr(0, 8'hC4);
    rd_chk("R8 ctrl layout", 0, 8'hC4);
    wr(0, 8'h20);
    cmp("R8 ovf at bit5", ovf_flag, 1);
    wr(0, 8'h00);

    phase = "R2";
    wr(0, 8'h10);
    strobes(5);
    wr(0, 8'h00);
    rd_chk("R2 five strobes", 1, 8'h39);

    phase = "R5";
    strobes(3);
    rd_chk("R5 stopped hold", 1, 8'h39);

    phase = "R6";
    wr(1, 8'hFE); wr(2, 8'hFF); wr(0, 8'h10);
    strobes(3);
    cmp("R6 ovf set", ovf_flag, 1);
    rd_chk("R6 cnt lo", 1, 8'hCE); rd_chk("R6 cnt hi", 2, 8'hAB);
    rd_chk("R6 rld kept", 3, 8'hCD);

    phase = "R7";
    ack_tmr = 1; cyc(1); ack_tmr = 0;
    cmp("R7 ack clears", ovf_flag, 0);
    wr(1, 8'hFF); wr(2, 8'hFF);
    mc_stb = 1; ack_tmr = 1; cyc(1); mc_stb = 0; ack_tmr = 0;
    cmp("R7 ovf beats ack", ovf_flag, 1);
    rd_chk("R7 wrapped lo", 1, 8'hCD);

    phase = "R11";
    reg_wr = 1; reg_addr = 3'd1; reg_wdata = 8'h55; mc_stb = 1;
    cyc(1);
    reg_wr = 0; mc_stb = 0;
    rd_chk("R11 written byte", 1, 8'h55);
    rd_chk("R11 no increment", 2, 8'hAB);
    ack_tmr = 1; cyc(1); ack_tmr = 0;

    phase = "R3";
    wr(0, 8'h50); wr(1, 0); wr(2, 0);
    set_cnt_pin(1); strobes(2);
    set_cnt_pin(0); strobes(2);
    set_cnt_pin(1); strobes(1);
    set_cnt_pin(0); strobes(1);
    set_cnt_pin(1); strobes(1);
    cnt_pin = 0; cyc(4); cnt_pin = 1; cyc(4);
    strobes(1);
    rd_chk("R3 pin falls counted", 1, 8'h02);

    phase = "R4";
    wr(0, 8'h90);
    irq0_pin = 0; cyc(4); strobes(3);
    rd_chk("R4 gate closed", 1, 8'h02);
    irq0_pin = 1; cyc(4); strobes(3);
    rd_chk("R4 gate open", 1, 8'h05);
    wr(0, 8'h00);

    phase = "R10";
    irq1_pin = 0; cyc(4);
    cmp("R10 level low", x1_req, 1);
    wr(0, 8'h00);
    cmp("R10 write ignored", x1_req, 1);
    ack_x1 = 1; cyc(1); ack_x1 = 0;
    cmp("R10 ack ignored", x1_req, 1);
    irq1_pin = 1; cyc(4);
    cmp("R10 level high", x1_req, 0);
    wr(0, 8'h02); cyc(1);
    cmp("R10 write one ignored", x1_req, 0);
    wr(0, 8'h00);

    phase = "R9";
    wr(0, 8'h05);
    irq0_pin = 0; cyc(4);
    cmp("R9 edge sets", x0_req, 1);
    irq0_pin = 1; cyc(4);
    cmp("R9 latched", x0_req, 1);
    ack_x0 = 1; cyc(1); ack_x0 = 0;
    cmp("R9 ack clears", x0_req, 0);
    irq0_pin = 0; cyc(4); irq0_pin = 1; cyc(4);
    irq0_pin = 0; cyc(2);
    ack_x0 = 1; cyc(1); ack_x0 = 0;
    cmp("R9 edge beats ack", x0_req, 1);
    irq1_pin = 0; cyc(4);
    cmp("R9 irq1 edge", x1_req, 1);
    ack_x1 = 1; cyc(1); ack_x1 = 0;
    cmp("R9 irq1 ack", x1_req, 0);
    cyc(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog %s actual=hung expected=finished", phase);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule